// File: doc/BRIEF.md
# Sectored Fully Associative Cache Directory

This block holds the tags and per-sector state of a fully associative cache. Each line is split into sectors of several words. Every line records its line address and three bits per sector: present, dirty and referenced. A client sends read or write probes that carry a word address and a flag marking the probe as caused by a jump. The directory answers each probe with one of three results: a hit, a sector miss (the line is resident but the addressed sector is not), or a line miss. On either kind of miss it asks memory for exactly one sector.

On a line miss, a separate selector names the line to replace through `victim_idx`. The directory then drains the dirty sectors of that line. Each dirty sector becomes one write-back request on a valid/ready channel. No new probe is accepted until the last of these requests has been taken. After that, the new line is installed with only the requested sector present.

The block also keeps statistics counters: probes, reads, writes, sector misses, line misses, write misses, jump misses, writes to clean sectors, and sector write-backs. It also keeps a histogram of how many sectors are present in a line right after each miss.

Top module: `sect_dir`

## Requirements
- R1: After reset no line is valid. Every counter and every `line_refd` bit is zero, `rsp_valid` and `wb_valid` are low, and `probe_ready` is high. Any first probe is a line miss.
- R2: The line address is the word address with its low log2(NSEC*WPS) bits cleared. The sector index is the word offset within the line shifted right by log2(WPS); with the defaults this is address bit 2. `fetch_addr` is the probe address with its low log2(WPS) bits cleared.
- R3: A probe whose line is resident and whose sector is present answers with `rsp_kind` 0 (hit) and `fetch_valid` low.
- R4: A probe whose line is resident but whose sector is absent answers with `rsp_kind` 1. It raises `fetch_valid`, sets that sector present, and increments the sector-miss counter.
- R5: A write marks its sector dirty. The writes-to-clean counter increments only when that bit was clear before, which is always the case on a line miss.
- R6: On a line miss, each dirty sector of a valid victim produces one write-back request, in ascending sector order, at the victim line address plus sector*WPS. `wb_valid` and `wb_addr` hold until `wb_ready`. The write-back counter increments once per accepted request. `probe_ready` stays low meanwhile.
- R7: A line miss answers with `rsp_kind` 2 and raises `fetch_valid`. It leaves the new line with only the requested sector present and with no dirty sectors, except the requested sector when the probe is a write.
- R8: Probes, reads and writes are counted. Write misses and jump misses are each counted for both sector misses and line misses, and line misses are counted.
- R9: On each miss, histogram bin k (k = 1..NSEC, at `st_hist[(k-1)*CW +: CW]`) increments, where k is the number of sectors present in the line after the fill. A line miss always uses bin 1.
- R10: A line miss replaces the line named by `victim_idx`. The replaced line address misses afterwards, and every other resident line still hits.
- R11: Bit i of `line_refd` goes high when line i is accessed by a hit or a fill. `ref_clr[i]` clears the referenced bits of line i, except the sector being accessed in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| probe_valid | input | 1 | probe request |
| probe_ready | output | 1 | directory can accept a probe |
| probe_write | input | 1 | probe is a write |
| probe_jump | input | 1 | probe is caused by a jump |
| probe_addr | input | AW | word address |
| victim_idx | input | log2(NLINES) | replacement line from the selector, sampled at lookup |
| rsp_valid | output | 1 | one-cycle result pulse |
| rsp_kind | output | 2 | 0 hit, 1 sector miss, 2 line miss |
| fetch_valid | output | 1 | sector fetch request, with rsp_valid |
| fetch_addr | output | AW | word address of the sector to fetch |
| wb_valid | output | 1 | write-back request |
| wb_ready | input | 1 | write-back accepted |
| wb_addr | output | AW | word address of the dirty sector |
| line_refd | output | NLINES | per-line referenced summary |
| ref_clr | input | NLINES | clear referenced bits per line |
| st_probes | output | CW | completed probes |
| st_reads | output | CW | read probes |
| st_writes | output | CW | write probes |
| st_sec_miss | output | CW | sector misses |
| st_line_miss | output | CW | line misses |
| st_wr_miss | output | CW | misses by writes |
| st_jmp_miss | output | CW | misses by jumps |
| st_wr_clean | output | CW | writes to clean sectors |
| st_wb | output | CW | sector write-backs |
| st_hist | output | NSEC*CW | present-sector histogram, bin 1 lowest |

## Verification
A wrong present bit turns a later access into the wrong result kind. It shows on `rsp_kind` and `fetch_valid` at the next probe to that sector. A lost or extra dirty bit shows only when the line is evicted, as a missing, extra or misordered `wb_addr`. The reference model therefore evicts lines that were written and lines that were not. A wrong tag or valid bit shows as a duplicate or missing hit on the next probe to either address. Counter mistakes show right away on the counter outputs, which are compared after every response.

// File: rtl/sdir_pkg.sv
package sdir_pkg;
   typedef enum logic [1:0] {
      RES_HIT      = 2'd0,
      RES_SECMISS  = 2'd1,
      RES_LINEMISS = 2'd2
   } res_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_WB   = 2'd2,
      ST_FILL = 2'd3
   } dir_state_e;

   function automatic int popc(input logic [63:0] v);
      int n;
      n = 0;
      for (int i = 0; i < 64; i++) n += int'(v[i]);
      return n;
   endfunction
endpackage

// File: rtl/sdir_match.sv
module sdir_match #(
   parameter int NLINES = 16,
   parameter int TW     = 13,
   localparam int LIB   = $clog2(NLINES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NLINES-1:0]          vld,
   input  logic [NLINES-1:0][TW-1:0]  tags,
   input  logic [TW-1:0]              key,
   output logic                       hit,
   output logic [LIB-1:0]             hit_idx
);
   logic [NLINES-1:0] match;

   for (genvar i = 0; i < NLINES; i++) begin : g_cmp
      assign match[i] = vld[i] && (tags[i] == key);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = NLINES - 1; i >= 0; i--)
         if (match[i]) hit_idx = LIB'(i);
   end
   assign hit = |match;

   // R10: a line address is resident in at most one line
   p_unique_r10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
endmodule

// File: rtl/sdir_stats.sv
module sdir_stats #(
   parameter int NSEC = 2,
   parameter int CW   = 16,
   localparam int HBW = $clog2(NSEC + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ev_done,
   input  logic                 ev_write,
   input  logic                 ev_jump,
   input  logic                 ev_secmiss,
   input  logic                 ev_linemiss,
   input  logic                 ev_wclean,
   input  logic                 ev_wb,
   input  logic [HBW-1:0]       hist_bin,
   output logic [CW-1:0]        st_probes,
   output logic [CW-1:0]        st_reads,
   output logic [CW-1:0]        st_writes,
   output logic [CW-1:0]        st_sec_miss,
   output logic [CW-1:0]        st_line_miss,
   output logic [CW-1:0]        st_wr_miss,
   output logic [CW-1:0]        st_jmp_miss,
   output logic [CW-1:0]        st_wr_clean,
   output logic [CW-1:0]        st_wb,
   output logic [NSEC*CW-1:0]   st_hist
);
   logic any_miss;
   assign any_miss = ev_secmiss | ev_linemiss;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_probes <= '0; st_reads <= '0; st_writes <= '0;
         st_sec_miss <= '0; st_line_miss <= '0; st_wr_miss <= '0;
         st_jmp_miss <= '0; st_wr_clean <= '0; st_wb <= '0;
      end else begin
         if (ev_done) st_probes <= st_probes + 1'b1;
         if (ev_done && !ev_write) st_reads <= st_reads + 1'b1;
         if (ev_done && ev_write) st_writes <= st_writes + 1'b1;
         if (ev_secmiss) st_sec_miss <= st_sec_miss + 1'b1;
         if (ev_linemiss) st_line_miss <= st_line_miss + 1'b1;
         if (any_miss && ev_write) st_wr_miss <= st_wr_miss + 1'b1;
         if (any_miss && ev_jump) st_jmp_miss <= st_jmp_miss + 1'b1;
         if (ev_wclean) st_wr_clean <= st_wr_clean + 1'b1;
         if (ev_wb) st_wb <= st_wb + 1'b1;
      end
   end

   for (genvar b = 0; b < NSEC; b++) begin : g_bin
      always_ff @(posedge clk) begin
         if (!rst_n) st_hist[b*CW +: CW] <= '0;
         else if (any_miss && hist_bin == HBW'(b + 1))
            st_hist[b*CW +: CW] <= st_hist[b*CW +: CW] + 1'b1;
      end
   end

   // R8: write misses never outnumber all misses
   p_wrmiss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (CW+1)'(st_wr_miss) <= (CW+1)'(st_sec_miss) + (CW+1)'(st_line_miss));
   // R9: a miss always lands in a bin between 1 and NSEC
   p_bin_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      any_miss |-> (hist_bin != '0 && hist_bin <= HBW'(NSEC)));
endmodule

// File: rtl/sect_dir.sv
module sect_dir
   import sdir_pkg::*;
#(
   parameter int AW     = 16,
   parameter int NLINES = 16,
   parameter int NSEC   = 2,
   parameter int WPS    = 4,
   parameter int CW     = 16,
   localparam int LIB   = $clog2(NLINES),
   localparam int WPSB  = $clog2(WPS),
   localparam int SECB  = $clog2(NSEC),
   localparam int OFFB  = WPSB + SECB,
   localparam int TW    = AW - OFFB,
   localparam int HBW   = $clog2(NSEC + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                probe_valid,
   output logic                probe_ready,
   input  logic                probe_write,
   input  logic                probe_jump,
   input  logic [AW-1:0]       probe_addr,
   input  logic [LIB-1:0]      victim_idx,
   output logic                rsp_valid,
   output logic [1:0]          rsp_kind,
   output logic                fetch_valid,
   output logic [AW-1:0]       fetch_addr,
   output logic                wb_valid,
   input  logic                wb_ready,
   output logic [AW-1:0]       wb_addr,
   output logic [NLINES-1:0]   line_refd,
   input  logic [NLINES-1:0]   ref_clr,
   output logic [CW-1:0]       st_probes,
   output logic [CW-1:0]       st_reads,
   output logic [CW-1:0]       st_writes,
   output logic [CW-1:0]       st_sec_miss,
   output logic [CW-1:0]       st_line_miss,
   output logic [CW-1:0]       st_wr_miss,
   output logic [CW-1:0]       st_jmp_miss,
   output logic [CW-1:0]       st_wr_clean,
   output logic [CW-1:0]       st_wb,
   output logic [NSEC*CW-1:0]  st_hist
);
   if (NSEC < 2 || NSEC > 64 || (1 << SECB) != NSEC) begin : g_bad_nsec
      $error("NSEC must be a power of two between 2 and 64");
   end
   if (WPS < 1 || (1 << WPSB) != WPS) begin : g_bad_wps
      $error("WPS must be a power of two");
   end
   if ((1 << LIB) != NLINES || TW < 1) begin : g_bad_geom
      $error("NLINES must be a power of two and AW must exceed the line offset");
   end

   // line state
   logic [NLINES-1:0]           vld_q;
   logic [NLINES-1:0][TW-1:0]   tag_q;
   logic [NLINES-1:0][NSEC-1:0] pres_q, dirty_q, refd_q;

   // latched probe
   dir_state_e      st_q;
   logic            p_write, p_jump;
   logic [TW-1:0]   p_tag;
   logic [SECB-1:0] p_sec;
   logic [LIB-1:0]  vic_q;
   logic [TW-1:0]   vic_tag;
   logic [NSEC-1:0] wb_mask;

   logic            hit;
   logic [LIB-1:0]  hit_idx;
   logic [NSEC-1:0] sec_oh;
   logic [SECB-1:0] wb_sec;
   logic [NSEC-1:0] wb_oh;
   logic            hit_now, sec_absent, fill_now;
   logic            unused_lo;

   assign unused_lo = ^probe_addr[WPSB > 0 ? WPSB-1 : 0];

   sdir_match #(.NLINES(NLINES), .TW(TW)) u_match (
      .clk(clk), .rst_n(rst_n), .vld(vld_q), .tags(tag_q), .key(p_tag),
      .hit(hit), .hit_idx(hit_idx)
   );

   assign sec_oh     = NSEC'(1) << p_sec;
   assign hit_now    = (st_q == ST_LOOK) && hit;
   assign sec_absent = !pres_q[hit_idx][p_sec];
   assign fill_now   = (st_q == ST_FILL);
   assign probe_ready = (st_q == ST_IDLE);

   always_comb begin
      wb_sec = '0;
      for (int i = NSEC - 1; i >= 0; i--)
         if (wb_mask[i]) wb_sec = SECB'(i);
   end
   assign wb_oh    = NSEC'(1) << wb_sec;
   assign wb_valid = (st_q == ST_WB);
   if (WPSB > 0) begin : g_wb_lo
      assign wb_addr = {vic_tag, wb_sec, {WPSB{1'b0}}};
   end else begin : g_wb_nolo
      assign wb_addr = {vic_tag, wb_sec};
   end

   for (genvar i = 0; i < NLINES; i++) begin : g_refd
      assign line_refd[i] = |refd_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         vld_q <= '0; tag_q <= '0; pres_q <= '0; dirty_q <= '0; refd_q <= '0;
         p_write <= 1'b0; p_jump <= 1'b0; p_tag <= '0; p_sec <= '0;
         vic_q <= '0; vic_tag <= '0; wb_mask <= '0;
         rsp_valid <= 1'b0; rsp_kind <= '0; fetch_valid <= 1'b0; fetch_addr <= '0;
      end else begin
         rsp_valid   <= 1'b0;
         fetch_valid <= 1'b0;
         for (int i = 0; i < NLINES; i++)
            if (ref_clr[i]) refd_q[i] <= '0;
         if (WPSB > 0) fetch_addr <= AW'({p_tag, p_sec}) << WPSB;
         else          fetch_addr <= AW'({p_tag, p_sec});
         case (st_q)
            ST_IDLE: if (probe_valid) begin
               p_write <= probe_write;
               p_jump  <= probe_jump;
               p_tag   <= probe_addr[AW-1:OFFB];
               p_sec   <= probe_addr[OFFB-1:WPSB];
               st_q    <= ST_LOOK;
            end
            ST_LOOK: begin
               if (hit) begin
                  pres_q[hit_idx][p_sec] <= 1'b1;
                  refd_q[hit_idx][p_sec] <= 1'b1;
                  if (p_write) dirty_q[hit_idx][p_sec] <= 1'b1;
                  rsp_valid   <= 1'b1;
                  rsp_kind    <= sec_absent ? RES_SECMISS : RES_HIT;
                  fetch_valid <= sec_absent;
                  st_q        <= ST_IDLE;
               end else begin
                  vic_q   <= victim_idx;
                  vic_tag <= tag_q[victim_idx];
                  wb_mask <= vld_q[victim_idx] ? dirty_q[victim_idx] : '0;
                  st_q    <= (vld_q[victim_idx] && |dirty_q[victim_idx]) ? ST_WB : ST_FILL;
               end
            end
            ST_WB: if (wb_ready) begin
               wb_mask <= wb_mask & ~wb_oh;
               if ((wb_mask & ~wb_oh) == '0) st_q <= ST_FILL;
            end
            default: begin
               vld_q[vic_q]   <= 1'b1;
               tag_q[vic_q]   <= p_tag;
               pres_q[vic_q]  <= sec_oh;
               refd_q[vic_q]  <= sec_oh;
               dirty_q[vic_q] <= p_write ? sec_oh : '0;
               rsp_valid      <= 1'b1;
               rsp_kind       <= RES_LINEMISS;
               fetch_valid    <= 1'b1;
               st_q           <= ST_IDLE;
            end
         endcase
      end
   end

   // statistics events
   logic           ev_secmiss, ev_wclean;
   logic [HBW-1:0] hist_bin;
   assign ev_secmiss = hit_now && sec_absent;
   assign ev_wclean  = p_write && (fill_now || (hit_now && !dirty_q[hit_idx][p_sec]));
   assign hist_bin   = fill_now ? HBW'(1)
                                : HBW'(popc(64'(pres_q[hit_idx] | sec_oh)));

   sdir_stats #(.NSEC(NSEC), .CW(CW)) u_stats (
      .clk(clk), .rst_n(rst_n),
      .ev_done(hit_now || fill_now), .ev_write(p_write), .ev_jump(p_jump),
      .ev_secmiss(ev_secmiss), .ev_linemiss(fill_now), .ev_wclean(ev_wclean),
      .ev_wb(wb_valid && wb_ready), .hist_bin(hist_bin),
      .st_probes(st_probes), .st_reads(st_reads), .st_writes(st_writes),
      .st_sec_miss(st_sec_miss), .st_line_miss(st_line_miss), .st_wr_miss(st_wr_miss),
      .st_jmp_miss(st_jmp_miss), .st_wr_clean(st_wr_clean), .st_wb(st_wb),
      .st_hist(st_hist)
   );

   // R6: a pending write-back request holds its address until taken
   p_wb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
   // R6: no probe is accepted while write-backs drain
   p_wb_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> !probe_ready);
   // R4: a fetch only accompanies a miss response
   p_fetch_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> rsp_valid && rsp_kind != RES_HIT);
   // R7: a freshly filled line holds exactly one present sector
   p_fill_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_kind == RES_LINEMISS |-> $onehot(pres_q[vic_q]));
endmodule

// File: tb/sect_dir_test.sv
module sect_dir_test;
   localparam int NL = 16;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic probe_valid = 0, probe_write = 0, probe_jump = 0, wb_ready = 0;
   logic [15:0] probe_addr = '0;
   logic [3:0]  victim_idx = '0;
   logic [NL-1:0] ref_clr = '0;
   logic probe_ready, rsp_valid, fetch_valid, wb_valid;
   logic [1:0] rsp_kind;
   logic [15:0] fetch_addr, wb_addr;
   logic [NL-1:0] line_refd;
   logic [15:0] st_probes, st_reads, st_writes, st_sec_miss, st_line_miss;
   logic [15:0] st_wr_miss, st_jmp_miss, st_wr_clean, st_wb;
   logic [31:0] st_hist;

   sect_dir uut (
      .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid), .probe_ready(probe_ready),
      .probe_write(probe_write), .probe_jump(probe_jump), .probe_addr(probe_addr),
      .victim_idx(victim_idx), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .wb_valid(wb_valid),
      .wb_ready(wb_ready), .wb_addr(wb_addr), .line_refd(line_refd), .ref_clr(ref_clr),
      .st_probes(st_probes), .st_reads(st_reads), .st_writes(st_writes),
      .st_sec_miss(st_sec_miss), .st_line_miss(st_line_miss), .st_wr_miss(st_wr_miss),
      .st_jmp_miss(st_jmp_miss), .st_wr_clean(st_wr_clean), .st_wb(st_wb),
      .st_hist(st_hist)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   // reference model
   bit mvld[NL];
   int mtag[NL];
   bit mpres[NL][2], mdirty[NL][2], mref[NL][2];
   int m_probes = 0, m_reads = 0, m_writes = 0, m_secm = 0, m_linem = 0;
   int m_wrm = 0, m_jm = 0, m_wclean = 0, m_wb = 0;
   int m_hist[3] = '{0, 0, 0};

   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cmp_stats();
      chk(int'(st_probes) == m_probes, "R8 probes", int'(st_probes), m_probes);
      chk(int'(st_reads) == m_reads, "R8 reads", int'(st_reads), m_reads);
      chk(int'(st_writes) == m_writes, "R8 writes", int'(st_writes), m_writes);
      chk(int'(st_sec_miss) == m_secm, "R4 sector misses", int'(st_sec_miss), m_secm);
      chk(int'(st_line_miss) == m_linem, "R8 line misses", int'(st_line_miss), m_linem);
      chk(int'(st_wr_miss) == m_wrm, "R8 write misses", int'(st_wr_miss), m_wrm);
      chk(int'(st_jmp_miss) == m_jm, "R8 jump misses", int'(st_jmp_miss), m_jm);
      chk(int'(st_wr_clean) == m_wclean, "R5 writes to clean", int'(st_wr_clean), m_wclean);
      chk(int'(st_wb) == m_wb, "R6 write-backs", int'(st_wb), m_wb);
      chk(int'(st_hist[15:0]) == m_hist[1], "R9 bin1", int'(st_hist[15:0]), m_hist[1]);
      chk(int'(st_hist[31:16]) == m_hist[2], "R9 bin2", int'(st_hist[31:16]), m_hist[2]);
   endtask

   function automatic int exp_refd();
      int v = 0;
      for (int i = 0; i < NL; i++) if (mref[i][0] || mref[i][1]) v |= (1 << i);
      return v;
   endfunction

   task automatic probe(input bit wr, input bit jp, input int addr, input int vic);
      int tag = addr >> 3;
      int sec = (addr >> 2) & 1;
      int h = -1, kind, np, n;
      int exq[$];
      bit seen = 0;
      for (int i = 0; i < NL; i++) if (mvld[i] && mtag[i] == tag) h = i;
      m_probes++;
      if (wr) m_writes++; else m_reads++;
      if (h >= 0) begin
         kind = mpres[h][sec] ? 0 : 1;
         if (kind == 1) begin
            mpres[h][sec] = 1; m_secm++;
            np = int'(mpres[h][0]) + int'(mpres[h][1]);
            m_hist[np]++;
            if (wr) m_wrm++;
            if (jp) m_jm++;
         end
         mref[h][sec] = 1;
         if (wr) begin
            if (!mdirty[h][sec]) m_wclean++;
            mdirty[h][sec] = 1;
         end
      end else begin
         kind = 2;
         if (mvld[vic])
            for (int s = 0; s < 2; s++)
               if (mdirty[vic][s]) begin
                  exq.push_back((mtag[vic] << 3) | (s << 2));
                  m_wb++;
               end
         mvld[vic] = 1; mtag[vic] = tag;
         for (int s = 0; s < 2; s++) begin
            mpres[vic][s] = (s == sec); mref[vic][s] = (s == sec);
            mdirty[vic][s] = wr && (s == sec);
         end
         m_linem++; m_hist[1]++;
         if (wr) begin m_wrm++; m_wclean++; end
         if (jp) m_jm++;
      end
      @(negedge clk);
      chk(probe_ready == 1'b1, "R6 ready when idle", int'(probe_ready), 1);
      probe_valid = 1; probe_write = wr; probe_jump = jp;
      probe_addr = 16'(addr); victim_idx = 4'(vic);
      @(negedge clk);
      probe_valid = 0;
      n = 0;
      while (n < 60) begin
         if (wb_valid) begin
            chk(probe_ready == 1'b0, "R6 stalled", int'(probe_ready), 0);
            if (exq.size() == 0) chk(0, "R6 extra write-back", int'(wb_addr), -1);
            else begin
               chk(int'(wb_addr) == exq[0], "R6 write-back addr", int'(wb_addr), exq[0]);
               wb_ready = (cyc % 2 == 1);
               if (wb_ready) void'(exq.pop_front());
            end
         end else wb_ready = 0;
         if (rsp_valid) begin seen = 1; break; end
         @(negedge clk);
         n++;
      end
      wb_ready = 0;
      chk(seen, "R3 response seen", int'(seen), 1);
      chk(int'(rsp_kind) == kind, kind == 0 ? "R3 kind" : (kind == 1 ? "R4 kind" : "R7 kind"),
          int'(rsp_kind), kind);
      chk(int'(fetch_valid) == int'(kind != 0), "R4 fetch_valid", int'(fetch_valid), int'(kind != 0));
      if (kind != 0)
         chk(int'(fetch_addr) == (addr & ~3), "R2 fetch address", int'(fetch_addr), addr & ~3);
      chk(exq.size() == 0, "R6 write-backs all issued", exq.size(), 0);
      chk(int'(line_refd) == exp_refd(), "R11 referenced", int'(line_refd), exp_refd());
      cmp_stats();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NL; i++) begin
         mvld[i] = 0; mtag[i] = 0;
         for (int s = 0; s < 2; s++) begin mpres[i][s] = 0; mdirty[i][s] = 0; mref[i][s] = 0; end
      end
      repeat (3) @(posedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk(probe_ready == 1, "R1 ready", int'(probe_ready), 1);
      chk(rsp_valid == 0 && wb_valid == 0, "R1 outputs idle", int'({rsp_valid, wb_valid}), 0);
      chk(line_refd == '0, "R1 referenced clear", int'(line_refd), 0);
      cmp_stats();
      probe(0, 0, 'h0010, 0);   // R1 first probe misses, R7 fill
      probe(0, 0, 'h0011, 3);   // R3 hit same sector
      probe(0, 0, 'h0014, 3);   // R2 sector index bit, R4 sector miss, R9 bin2
      probe(1, 0, 'h0015, 3);   // R5 write to clean
      probe(1, 0, 'h0016, 3);   // R5 write to dirty: no count
      probe(1, 1, 'h0012, 3);   // R5 other sector clean
      probe(1, 1, 'h0100, 1);   // R8 write + jump line miss
      probe(0, 0, 'h0020, 0);   // R6 evict two dirty sectors
      probe(0, 0, 'h0010, 2);   // R10 replaced line now misses
      probe(0, 0, 'h0020, 3);   // R10 other lines still hit
      probe(0, 1, 'h0024, 3);   // R8 jump sector miss
      probe(1, 0, 'h0104, 3);   // R8 write sector miss
      probe(0, 0, 'h0200, 1);   // R6 two write-backs from line 1
      probe(0, 0, 'h0300, 0);   // R7 clean victim: no write-back
      probe(0, 0, 'h0300, 5);   // R3 hit
      // R11: clear referenced bits through ref_clr
      @(negedge clk);
      ref_clr = '1;
      @(negedge clk);
      ref_clr = '0;
      for (int i = 0; i < NL; i++) begin mref[i][0] = 0; mref[i][1] = 0; end
      chk(line_refd == '0, "R11 cleared", int'(line_refd), 0);
      // R10: fill every line then hit each
      for (int i = 0; i < NL; i++) probe(i % 3 == 0, 0, 'h1000 + i * 8 + (i % 2) * 4, i);
      for (int i = 0; i < NL; i++) probe(0, 0, 'h1000 + i * 8 + (i % 2) * 4, 0);
      for (int i = 0; i < NL; i++) probe(0, 0, 'h2000 + i * 8, i); // R6 write-backs of dirty lines
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule